// File: doc/BRIEF.md
# ECC Fault Capture Register

This block records diagnostic details when a memory read reports an error-correction fault. A single-bit (corrected) or a double-bit (uncorrectable) fault strobe causes the block to store several values: the parity bits of the failing word, its 23-bit global address, and up to four 16-bit data words. It also raises a sticky flag for the fault type. Software, or a bus decoder outside this block, reads the stored values through a 16-bit read-only window. A 3-bit index selects what the window shows, and the window is split into a high byte and a low byte.

The stored record is frozen while either fault flag is set, so the first fault is kept until it has been acknowledged. Each fault type has its own clear request. Two array types are supported. A wide array has 8 parity bits and four data words. A narrow array has 6 parity bits and one data word. The ECC logic and the bus decoding are outside this block.

Top module: `ecc_fault_capture`

## Requirements
- R1: While `rst` is high at a clock edge, both flags clear and every stored field becomes zero, so every index reads 0x0000 afterwards.
- R2: A `sbe_strobe` with no `dbe_strobe` sets `sbe_flag` and captures the inputs at that edge. Both are visible after the edge.
- R3: A `dbe_strobe` sets `dbe_flag` and captures the inputs at that edge.
- R4: When both strobes arrive in the same cycle, only `dbe_flag` is set; `sbe_flag` stays low if it was low.
- R5: While either flag is set and is not being cleared, no new fault changes the stored record. A new fault during that time still sets its own flag.
- R6: A flag stays set until its own clear request (`clr_sbe` or `clr_dbe`). It then reads low after that edge, provided no fault of that type arrives in the same cycle.
- R7: A clear request and a new fault in the same cycle leave the flag set. The new fault's information is captured, provided the other flag is not holding the lock.
- R8: Index 0 reads the stored parity in bits [15:8], 0 in bit 7, and global address bits [22:16] in bits [6:0].
- R9: Index 1 reads global address [15:0]. Index 2 reads data word 0, taken from `data_in[15:0]`.
- R10: Indices 3, 4 and 5 read data words 1, 2 and 3, taken from `data_in[31:16]`, `[47:32]` and `[63:48]`.
- R11: Indices 6 and 7 always read 0x0000.
- R12: For a fault captured with `mem_wide` low, stored parity bits [7:6] are 00, only `par_in[5:0]` is kept, and indices 3 to 5 read 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sbe_strobe | input | 1 | Single-bit fault reported this cycle |
| dbe_strobe | input | 1 | Double-bit fault reported this cycle |
| mem_wide | input | 1 | 1: wide array (8 parity, 4 words); 0: narrow array |
| par_in | input | 8 | Parity bits of the faulting word |
| gaddr_in | input | 23 | Global address of the faulting read |
| data_in | input | 64 | Data words 0..3, word k in bits [16k+15:16k] |
| clr_sbe | input | 1 | Clear request for the single-bit flag |
| clr_dbe | input | 1 | Clear request for the double-bit flag |
| idx | input | 3 | Result window select |
| sbe_flag | output | 1 | Sticky single-bit fault flag |
| dbe_flag | output | 1 | Sticky double-bit fault flag |
| res_hi | output | 8 | Result window bits [15:8] |
| res_lo | output | 8 | Result window bits [7:0] |

## Verification
Flags and stored fields update at the clock edge where a strobe or clear is sampled, so their effect is due one edge later. The result window is combinational from the held record and `idx`, so a new index is due in the same cycle. The bench drives every input on the falling edge and samples flags on the next falling edge, after exactly one rising edge. It reads the window a short delay after changing `idx`, with no clock edge in between, so each value is checked in the cycle it is due.

// File: rtl/ecc_cap_pkg.sv
package ecc_cap_pkg;
  // Window index codes; the layout of the window depends on these positions.
  typedef enum logic [2:0] {
    IX_PARADDR = 3'd0,
    IX_ADDRLO  = 3'd1,
    IX_WORD0   = 3'd2
  } win_ix_e;

  localparam int FIRST_WORD_IX = 2;
endpackage

// File: rtl/ecc_cap_flags.sv
module ecc_cap_flags (
  input  logic clk,
  input  logic rst,
  input  logic sbe_strobe,
  input  logic dbe_strobe,
  input  logic clr_sbe,
  input  logic clr_dbe,
  output logic sbe_q,
  output logic dbe_q,
  output logic cap_en
);
  logic lock;

  // Record stays locked while a flag is set and not being cleared this cycle
  assign lock   = (sbe_q & ~clr_sbe) | (dbe_q & ~clr_dbe);
  assign cap_en = ~lock & (sbe_strobe | dbe_strobe);

  always_ff @(posedge clk) begin
    if (rst) begin
      sbe_q <= 1'b0;
      dbe_q <= 1'b0;
    end else begin
      if (dbe_strobe)      dbe_q <= 1'b1;
      else if (clr_dbe)    dbe_q <= 1'b0;
      // A simultaneous double-bit fault takes precedence
      if (sbe_strobe && !dbe_strobe) sbe_q <= 1'b1;
      else if (clr_sbe)              sbe_q <= 1'b0;
    end
  end
endmodule

// File: rtl/ecc_cap_store.sv
module ecc_cap_store #(
  parameter int PAR_W   = 8,
  parameter int NPAR_W  = 6,
  parameter int ADDR_W  = 23,
  parameter int WORD_W  = 16,
  parameter int NWORDS  = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cap_en,
  input  logic                     mem_wide,
  input  logic [PAR_W-1:0]         par_in,
  input  logic [ADDR_W-1:0]        gaddr_in,
  input  logic [NWORDS*WORD_W-1:0] data_in,
  output logic [PAR_W-1:0]         par_q,
  output logic [ADDR_W-1:0]        addr_q,
  output logic [NWORDS*WORD_W-1:0] words_q
);
  localparam logic [PAR_W-1:0] NARROW_MASK = PAR_W'((1 << NPAR_W) - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      par_q  <= '0;
      addr_q <= '0;
    end else if (cap_en) begin
      par_q  <= mem_wide ? par_in : (par_in & NARROW_MASK);
      addr_q <= gaddr_in;
    end
  end

  for (genvar k = 0; k < NWORDS; k++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst) begin
        words_q[k*WORD_W +: WORD_W] <= '0;
      end else if (cap_en) begin
        if (k == 0 || mem_wide)
          words_q[k*WORD_W +: WORD_W] <= data_in[k*WORD_W +: WORD_W];
        else
          words_q[k*WORD_W +: WORD_W] <= '0;
      end
    end
  end
endmodule

// File: rtl/ecc_cap_window.sv
module ecc_cap_window
  import ecc_cap_pkg::*;
#(
  parameter int PAR_W   = 8,
  parameter int ADDR_W  = 23,
  parameter int WORD_W  = 16,
  parameter int NWORDS  = 4,
  parameter int IDX_W   = 3
) (
  input  logic [IDX_W-1:0]         idx,
  input  logic [PAR_W-1:0]         par_q,
  input  logic [ADDR_W-1:0]        addr_q,
  input  logic [NWORDS*WORD_W-1:0] words_q,
  output logic [WORD_W-1:0]        res
);
  localparam int HI_ADDR_W = ADDR_W - WORD_W;
  localparam int GAP_W     = WORD_W - PAR_W - HI_ADDR_W;

  logic [WORD_W-1:0] ix0_val;
  assign ix0_val = {par_q, {GAP_W{1'b0}}, addr_q[ADDR_W-1:WORD_W]};

  always_comb begin
    res = '0;
    if (idx == IDX_W'(IX_PARADDR))      res = ix0_val;
    else if (idx == IDX_W'(IX_ADDRLO))  res = addr_q[WORD_W-1:0];
    else begin
      for (int k = 0; k < NWORDS; k++)
        if (int'(idx) == FIRST_WORD_IX + k) res = words_q[k*WORD_W +: WORD_W];
    end
  end
endmodule

// File: rtl/ecc_fault_capture.sv
module ecc_fault_capture #(
  parameter int PAR_W   = 8,
  parameter int NPAR_W  = 6,
  parameter int ADDR_W  = 23,
  parameter int WORD_W  = 16,
  parameter int NWORDS  = 4,
  parameter int IDX_W   = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     sbe_strobe,
  input  logic                     dbe_strobe,
  input  logic                     mem_wide,
  input  logic [PAR_W-1:0]         par_in,
  input  logic [ADDR_W-1:0]        gaddr_in,
  input  logic [NWORDS*WORD_W-1:0] data_in,
  input  logic                     clr_sbe,
  input  logic                     clr_dbe,
  input  logic [IDX_W-1:0]         idx,
  output logic                     sbe_flag,
  output logic                     dbe_flag,
  output logic [WORD_W/2-1:0]      res_hi,
  output logic [WORD_W/2-1:0]      res_lo
);
  localparam int HALF = WORD_W / 2;

  logic                     cap_en;
  logic [PAR_W-1:0]         par_q;
  logic [ADDR_W-1:0]        addr_q;
  logic [NWORDS*WORD_W-1:0] words_q;
  logic [WORD_W-1:0]        res;

  ecc_cap_flags u_flags (
    .clk(clk), .rst(rst),
    .sbe_strobe(sbe_strobe), .dbe_strobe(dbe_strobe),
    .clr_sbe(clr_sbe), .clr_dbe(clr_dbe),
    .sbe_q(sbe_flag), .dbe_q(dbe_flag), .cap_en(cap_en)
  );

  ecc_cap_store #(
    .PAR_W(PAR_W), .NPAR_W(NPAR_W), .ADDR_W(ADDR_W),
    .WORD_W(WORD_W), .NWORDS(NWORDS)
  ) u_store (
    .clk(clk), .rst(rst), .cap_en(cap_en), .mem_wide(mem_wide),
    .par_in(par_in), .gaddr_in(gaddr_in), .data_in(data_in),
    .par_q(par_q), .addr_q(addr_q), .words_q(words_q)
  );

  ecc_cap_window #(
    .PAR_W(PAR_W), .ADDR_W(ADDR_W), .WORD_W(WORD_W),
    .NWORDS(NWORDS), .IDX_W(IDX_W)
  ) u_win (
    .idx(idx), .par_q(par_q), .addr_q(addr_q), .words_q(words_q), .res(res)
  );

  assign res_hi = res[WORD_W-1:HALF];
  assign res_lo = res[HALF-1:0];
endmodule

// File: rtl/ecc_fault_capture_chk.sv
module ecc_fault_capture_chk #(
  parameter int IDX_W = 3,
  parameter int HALF  = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             sbe_strobe,
  input logic             dbe_strobe,
  input logic             clr_sbe,
  input logic             clr_dbe,
  input logic [IDX_W-1:0] idx,
  input logic             sbe_flag,
  input logic             dbe_flag,
  input logic [HALF-1:0]  res_hi,
  input logic [HALF-1:0]  res_lo
);
  // R1
  reset_clears_chk: assert property (@(posedge clk) rst |=> (!sbe_flag && !dbe_flag));
  // R3
  dbe_sets_chk: assert property (@(posedge clk) disable iff (rst) dbe_strobe |=> dbe_flag);
  // R4
  dbe_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (sbe_strobe && dbe_strobe && !sbe_flag) |=> !sbe_flag);
  // R5
  frozen_chk: assert property (@(posedge clk) disable iff (rst)
    ((sbe_flag || dbe_flag) && !clr_sbe && !clr_dbe) |=>
      ($stable(idx) -> ($stable(res_hi) && $stable(res_lo))));
  // R6
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (sbe_flag && !clr_sbe) |=> sbe_flag);
  // R11
  unused_ix_chk: assert property (@(posedge clk) disable iff (rst)
    (idx[2:1] == 2'b11) |-> (res_hi == '0 && res_lo == '0));
  // R8
  gap_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (idx == '0) |-> !res_lo[HALF-1]);
endmodule

bind ecc_fault_capture ecc_fault_capture_chk #(.IDX_W(IDX_W), .HALF(WORD_W/2)) u_chk (
  .clk(clk), .rst(rst), .sbe_strobe(sbe_strobe), .dbe_strobe(dbe_strobe),
  .clr_sbe(clr_sbe), .clr_dbe(clr_dbe), .idx(idx),
  .sbe_flag(sbe_flag), .dbe_flag(dbe_flag), .res_hi(res_hi), .res_lo(res_lo)
);

// File: tb/sim_ecc_fault_capture.sv
`timescale 1ns/1ps
module sim_ecc_fault_capture;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sbe_strobe = 0, dbe_strobe = 0, mem_wide = 1;
  logic [7:0]  par_in = 0;
  logic [22:0] gaddr_in = 0;
  logic [63:0] data_in = 0;
  logic        clr_sbe = 0, clr_dbe = 0;
  logic [2:0]  idx = 0;
  logic        sbe_flag, dbe_flag;
  logic [7:0]  res_hi, res_lo;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ecc_fault_capture u0 (
    .clk(clk), .rst(rst), .sbe_strobe(sbe_strobe), .dbe_strobe(dbe_strobe),
    .mem_wide(mem_wide), .par_in(par_in), .gaddr_in(gaddr_in), .data_in(data_in),
    .clr_sbe(clr_sbe), .clr_dbe(clr_dbe), .idx(idx),
    .sbe_flag(sbe_flag), .dbe_flag(dbe_flag), .res_hi(res_hi), .res_lo(res_lo)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [2:0] i, output logic [15:0] v);
    idx = i;
    #1;
    v = {res_hi, res_lo};
  endtask

  // Drive for one rising edge, then release at the following falling edge
  task automatic step(bit s, bit d, bit w, logic [7:0] p, logic [22:0] a,
                      logic [63:0] dt, bit cs, bit cd);
    sbe_strobe = s; dbe_strobe = d; mem_wide = w; par_in = p;
    gaddr_in = a; data_in = dt; clr_sbe = cs; clr_dbe = cd;
    @(negedge clk);
    sbe_strobe = 0; dbe_strobe = 0; clr_sbe = 0; clr_dbe = 0;
  endtask

  task automatic clear_all();
    step(0, 0, 1, 8'h00, 23'h0, 64'h0, 1, 1);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    chk("R1 sbe_flag", sbe_flag, 0);
    chk("R1 dbe_flag", dbe_flag, 0);
    for (int i = 0; i < 8; i++) begin
      rd(i[2:0], v);
      chk("R1 index zero", v, 0);
    end
  endtask

  task automatic t_single_wide();
    logic [15:0] v;
    step(1, 0, 1, 8'hA5, 23'h5A_1234, 64'h4444_3333_2222_1111, 0, 0);
    chk("R2 sbe_flag", sbe_flag, 1);
    chk("R2 dbe_flag low", dbe_flag, 0);
    rd(0, v); chk("R8 index0", v, 16'hA55A);
    rd(1, v); chk("R9 addr low", v, 16'h1234);
    rd(2, v); chk("R9 word0", v, 16'h1111);
    rd(3, v); chk("R10 word1", v, 16'h2222);
    rd(4, v); chk("R10 word2", v, 16'h3333);
    rd(5, v); chk("R10 word3", v, 16'h4444);
    rd(6, v); chk("R11 index6", v, 0);
    rd(7, v); chk("R11 index7", v, 0);
  endtask

  task automatic t_freeze();
    logic [15:0] v;
    step(0, 1, 1, 8'hFF, 23'h7F_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0);
    chk("R5 dbe flag still set", dbe_flag, 1);
    rd(0, v); chk("R5 index0 frozen", v, 16'hA55A);
    rd(5, v); chk("R5 word3 frozen", v, 16'h4444);
    // release single flag only: double still locks
    step(1, 0, 1, 8'h11, 23'h00_0011, 64'h11, 1, 0);
    rd(1, v); chk("R5 locked by other flag", v, 16'h1234);
    chk("R7 sbe kept by new fault", sbe_flag, 1);
  endtask

  task automatic t_clear();
    step(0, 0, 1, 8'h00, 23'h0, 64'h0, 1, 0);
    chk("R6 sbe cleared", sbe_flag, 0);
    chk("R6 dbe untouched", dbe_flag, 1);
    step(0, 0, 1, 8'h00, 23'h0, 64'h0, 0, 1);
    chk("R6 dbe cleared", dbe_flag, 0);
  endtask

  task automatic t_double();
    logic [15:0] v;
    step(0, 1, 1, 8'h3C, 23'h01_0203, 64'hDDDD_CCCC_BBBB_AAAA, 0, 0);
    chk("R3 dbe_flag", dbe_flag, 1);
    chk("R3 sbe low", sbe_flag, 0);
    rd(0, v); chk("R3 index0", v, 16'h3C01);
    rd(2, v); chk("R3 word0", v, 16'hAAAA);
    // clear with a new fault in the same cycle
    step(0, 1, 1, 8'h77, 23'h02_BEEF, 64'h1, 0, 1);
    chk("R7 dbe stays set", dbe_flag, 1);
    rd(1, v); chk("R7 new addr captured", v, 16'hBEEF);
    rd(0, v); chk("R7 new parity captured", v, 16'h7702);
    clear_all();
  endtask

  task automatic t_simul();
    step(1, 1, 1, 8'h01, 23'h1, 64'h1, 0, 0);
    chk("R4 dbe set", dbe_flag, 1);
    chk("R4 sbe not set", sbe_flag, 0);
    clear_all();
    chk("R6 both clear", {sbe_flag, dbe_flag}, 0);
  endtask

  task automatic t_narrow();
    logic [15:0] v;
    step(1, 0, 0, 8'hFF, 23'h12_3456, 64'h9999_8888_7777_6666, 0, 0);
    rd(0, v); chk("R12 parity masked", v, 16'h3F12);
    rd(2, v); chk("R12 word0 kept", v, 16'h6666);
    rd(3, v); chk("R12 word1 zero", v, 0);
    rd(4, v); chk("R12 word2 zero", v, 0);
    rd(5, v); chk("R12 word3 zero", v, 0);
    clear_all();
  endtask

  task automatic t_reset_mid();
    logic [15:0] v;
    step(0, 1, 1, 8'h55, 23'h7F_0001, 64'h5, 0, 0);
    rst = 1;
    @(negedge clk);
    rst = 0;
    chk("R1 dbe after reset", dbe_flag, 0);
    rd(0, v); chk("R1 index0 after reset", v, 0);
    rd(2, v); chk("R1 word0 after reset", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_single_wide();
    t_freeze();
    t_clear();
    t_double();
    t_simul();
    t_narrow();
    t_reset_mid();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule